// File: doc/BRIEF.md
# Synchronous Up/Down Counter with Preset and Cascade Carry

This block is a four-bit synchronous counter. It counts up or down under a direction input, and a range input selects binary (0 to 15) or decade (0 to 9) at run time. A load input copies a parallel data word into the count. A reset clears the count. An active-low carry input enables counting. An active-low carry output marks the terminal state of the stage, so that several stages can be chained on one clock.

To build a multi-digit counter, every stage gets the same clock, direction, range, load and reset. Each stage's carry output drives the carry input of the next, more significant, stage. The least significant stage has its carry input tied low, or driven as a global count enable. All state changes happen on the rising clock edge, so every output bit of every stage changes in the same cycle.

Top module: `updn_preset_counter`

## Requirements
- R1: The count changes only on a rising clock edge, and all count bits take their new value in the same cycle.
- R2: In the counting state (carry input low, no load, no reset) with direction high, the count increases by one each cycle. In binary range (range input high) the count goes from 15 to 0.
- R3: In the counting state with direction low, the count decreases by one each cycle. In binary range the count goes from 0 to 15.
- R4: In decade range (range input low), counting up from 9 gives 0, and counting down from 0 gives 9.
- R5: When load is high at a clock edge, the count takes the value of the data input (bit 0 is the least significant weight). A data word of all zeros therefore clears the count.
- R6: When the carry input is high and neither load nor reset is active, the count keeps its value at every clock edge.
- R7: When reset is high at a clock edge, the count becomes 0, even if load is high at that edge.
- R8: Load takes effect whatever the carry input level is. Load takes priority over counting and over holding.
- R9: The carry output is low only when the carry input is low and the count is at its terminal value. The terminal value is 15 (binary range) or 9 (decade range) when counting up, and 0 when counting down. Otherwise the carry output is high. The carry output is combinational.
- R10: In decade range, a loaded count of 10 to 15 counts up by one per cycle and goes from 15 to 0. It counts down by one per cycle. The counter does not lock up in these values.
- R11: Two stages on a shared clock, with the low stage's carry output feeding the high stage's carry input, count together as one two-digit counter. The high stage moves once each time the low stage passes its terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high clear |
| up_dn | input | 1 | Count direction: 1 up, 0 down |
| bin_dec | input | 1 | Range select: 1 binary (0-15), 0 decade (0-9) |
| load | input | 1 | Synchronous parallel load of `din` |
| cin_n | input | 1 | Active-low count enable / carry input |
| din | input | 4 | Parallel load data |
| q | output | 4 | Current count |
| cout_n | output | 1 | Active-low carry output to the next stage |

## Verification
The assertions assume that every control input has a known value at each rising edge. They also assume that reset is high at the first edge, because the count has no defined value until the first reset or load. The bench keeps to this: it asserts reset from time zero and changes inputs only on the falling clock edge, so every input is settled well before the next rising edge. Direction and range changes therefore happen between edges and never inside a sampling window.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef enum logic {
        RANGE_DEC = 1'b0,
        RANGE_BIN = 1'b1
    } range_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef struct packed {
        dir_e   dir;
        range_e rng;
        logic   run;
    } ctrl_t;

    // Priority: clear, then load, then step, else hold.
    function automatic op_e pick_op(input logic clr, input logic ld, input logic run);
        if (clr)      return OP_CLEAR;
        else if (ld)  return OP_LOAD;
        else if (run) return OP_STEP;
        else          return OP_HOLD;
    endfunction

endpackage

// File: rtl/updn_cnt_ctrl.sv
module updn_cnt_ctrl
    import updn_cnt_pkg::*;
(
    input  logic  rst,
    input  logic  up_dn,
    input  logic  bin_dec,
    input  logic  load,
    input  logic  cin_n,
    output ctrl_t ctrl,
    output op_e   op
);
    always_comb begin
        ctrl.dir = up_dn   ? DIR_UP    : DIR_DOWN;
        ctrl.rng = bin_dec ? RANGE_BIN : RANGE_DEC;
        ctrl.run = ~cin_n;
        op       = pick_op(rst, load, ~cin_n);
    end
endmodule

// File: rtl/updn_cnt_step.sv
module updn_cnt_step
    import updn_cnt_pkg::*;
#(
    parameter int W        = 4,
    parameter int DEC_LAST = 9
) (
    input  logic [W-1:0] cur,
    input  ctrl_t        ctrl,
    output logic [W-1:0] nxt,
    output logic         at_term
);
    localparam logic [W-1:0] BIN_LAST = '1;
    localparam logic [W-1:0] DEC_TOP  = W'(DEC_LAST);
    localparam logic [W-1:0] ONE      = W'(1);

    logic [W-1:0] last;
    logic         at_last;
    logic         at_zero;

    always_comb begin
        last    = (ctrl.rng == RANGE_BIN) ? BIN_LAST : DEC_TOP;
        at_last = (cur == last);
        at_zero = (cur == '0);
        if (ctrl.dir == DIR_UP) begin
            nxt     = at_last ? '0 : cur + ONE;
            at_term = at_last;
        end else begin
            nxt     = at_zero ? last : cur - ONE;
            at_term = at_zero;
        end
    end
endmodule

// File: rtl/updn_cnt_reg.sv
module updn_cnt_reg
    import updn_cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  op_e          op,
    input  logic [W-1:0] step_val,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        unique case (op)
            OP_CLEAR: q <= '0;
            OP_LOAD:  q <= load_val;
            OP_STEP:  q <= step_val;
            default:  q <= q;
        endcase
    end
endmodule

// File: rtl/updn_preset_counter.sv
module updn_preset_counter
    import updn_cnt_pkg::*;
#(
    parameter int W        = 4,
    parameter int DEC_LAST = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         up_dn,
    input  logic         bin_dec,
    input  logic         load,
    input  logic         cin_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         cout_n
);
    ctrl_t        ctrl;
    op_e          op;
    logic [W-1:0] step_val;
    logic         at_term;

    updn_cnt_ctrl u_ctrl (
        .rst     (rst),
        .up_dn   (up_dn),
        .bin_dec (bin_dec),
        .load    (load),
        .cin_n   (cin_n),
        .ctrl    (ctrl),
        .op      (op)
    );

    updn_cnt_step #(.W(W), .DEC_LAST(DEC_LAST)) u_step (
        .cur     (q),
        .ctrl    (ctrl),
        .nxt     (step_val),
        .at_term (at_term)
    );

    updn_cnt_reg #(.W(W)) u_reg (
        .clk      (clk),
        .op       (op),
        .step_val (step_val),
        .load_val (din),
        .q        (q)
    );

    assign cout_n = ~(ctrl.run & at_term);
endmodule

// File: rtl/updn_preset_counter_chk.sv
module updn_preset_counter_chk #(
    parameter int W        = 4,
    parameter int DEC_LAST = 9
) (
    input logic         clk,
    input logic         rst,
    input logic         up_dn,
    input logic         bin_dec,
    input logic         load,
    input logic         cin_n,
    input logic [W-1:0] din,
    input logic [W-1:0] q,
    input logic         cout_n
);
    localparam logic [W-1:0] ONE = W'(1);
    logic [W-1:0] top_c;
    assign top_c = bin_dec ? '1 : W'(DEC_LAST);

    p_reset_clears_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> q == '0);

    p_load_takes_din_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(din));

    p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && cin_n) |=> $stable(q));

    p_count_up_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && !cin_n && up_dn && q != top_c) |=> q == W'($past(q) + ONE));

    p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && !cin_n && !up_dn && q != '0) |=> q == W'($past(q) - ONE));

    p_wrap_up_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && !cin_n && up_dn && q == top_c) |=> q == '0);

    p_wrap_down_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && !cin_n && !up_dn && q == '0) |=> q == $past(top_c));

    p_carry_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
        !cout_n |-> (!cin_n && (up_dn ? q == top_c : q == '0)));
endmodule

bind updn_preset_counter updn_preset_counter_chk #(.W(W), .DEC_LAST(DEC_LAST)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .up_dn   (up_dn),
    .bin_dec (bin_dec),
    .load    (load),
    .cin_n   (cin_n),
    .din     (din),
    .q       (q),
    .cout_n  (cout_n)
);

// File: tb/updn_preset_counter_bench.sv
module updn_preset_counter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       up_dn = 1'b1;
    logic       bin_dec = 1'b1;
    logic       load = 1'b0;
    logic       cin_n = 1'b1;
    logic [3:0] din = 4'd0;
    logic [3:0] din_hi = 4'd0;
    logic [3:0] q_lo, q_hi;
    logic       cout_lo, cout_hi;

    int checks = 0;
    int errors = 0;
    int m_lo = 0;
    int m_hi = 0;
    bit done = 0;

    always #10 clk = ~clk;

    updn_preset_counter u_updn_preset_counter (
        .clk(clk), .rst(rst), .up_dn(up_dn), .bin_dec(bin_dec), .load(load),
        .cin_n(cin_n), .din(din), .q(q_lo), .cout_n(cout_lo)
    );

    updn_preset_counter u_hi (
        .clk(clk), .rst(rst), .up_dn(up_dn), .bin_dec(bin_dec), .load(load),
        .cin_n(cout_lo), .din(din_hi), .q(q_hi), .cout_n(cout_hi)
    );

    function automatic int m_next(int cur, bit r, bit ld, int d, bit cn, bit up, bit bin);
        int top = bin ? 15 : 9;
        if (r)       return 0;
        if (ld)      return d;
        if (cn)      return cur;
        if (up)      return (cur == top) ? 0 : (cur + 1) % 16;
        return (cur == 0) ? top : cur - 1;
    endfunction

    function automatic bit m_cout(int cur, bit cn, bit up, bit bin);
        int top = bin ? 15 : 9;
        return !(!cn && (up ? cur == top : cur == 0));
    endfunction

    task automatic chk(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drives inputs after a falling edge, checks carries before the rising
    // edge, then checks both counts after the following falling edge.
    task automatic cyc(bit r, bit ld, bit cn, bit up, bit bin, int d, int dh, string tag);
        bit ec_lo, ec_hi;
        rst = r; load = ld; cin_n = cn; up_dn = up; bin_dec = bin;
        din = 4'(d); din_hi = 4'(dh);
        #2;
        ec_lo = m_cout(m_lo, cn, up, bin);
        ec_hi = m_cout(m_hi, ec_lo, up, bin);
        if (!r) begin
            chk(int'(cout_lo), int'(ec_lo), "R9");
            chk(int'(cout_hi), int'(ec_hi), "R11");
        end
        @(posedge clk);
        @(negedge clk);
        m_lo = m_next(m_lo, r, ld, d, cn, up, bin);
        m_hi = m_next(m_hi, r, ld, dh, ec_lo, up, bin);
        chk(int'(q_lo), m_lo, tag);
        chk(int'(q_hi), m_hi, "R11");
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(1, 0, 1, 1, 1, 0, 0, "R7");
        chk(int'(q_lo), 0, "R7");

        // binary up past 15 and chain carry
        for (int i = 0; i < 40; i++) cyc(0, 0, 0, 1, 1, 0, 0, "R2");
        // binary down through 0
        for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 1, 0, 0, "R3");
        // all bits change together: 7 -> 8
        cyc(0, 1, 0, 1, 1, 7, 0, "R5");
        cyc(0, 0, 0, 1, 1, 0, 0, "R1");
        chk(int'(q_lo), 8, "R1");
        // decade up and down with wrap
        cyc(1, 0, 1, 1, 0, 0, 0, "R7");
        for (int i = 0; i < 30; i++) cyc(0, 0, 0, 1, 0, 0, 0, "R4");
        for (int i = 0; i < 30; i++) cyc(0, 0, 0, 0, 0, 0, 0, "R4");
        // hold
        cyc(0, 1, 1, 1, 1, 11, 3, "R8");
        chk(int'(q_lo), 11, "R8");
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, 1, 4, 4, "R6");
        chk(int'(q_lo), 11, "R6");
        // load zeros clears
        cyc(0, 1, 0, 1, 1, 0, 0, "R5");
        chk(int'(q_lo), 0, "R5");
        // reset wins over load
        cyc(1, 1, 0, 1, 1, 9, 9, "R7");
        chk(int'(q_lo), 0, "R7");
        // decade range, out-of-range values
        cyc(0, 1, 0, 1, 0, 12, 0, "R10");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0, 0, 0, "R10");
        chk(int'(q_lo), 1, "R10");
        cyc(0, 1, 0, 0, 0, 13, 0, "R10");
        cyc(0, 0, 0, 0, 0, 0, 0, "R10");
        chk(int'(q_lo), 12, "R10");
        // mixed stimulus
        for (int i = 0; i < 600; i++) begin
            int sel = int'($urandom_range(0, 99));
            cyc(sel < 2, sel >= 2 && sel < 7, sel >= 7 && sel < 15,
                bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), "R1");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule